// File: doc/BRIEF.md
# Dense-Layer Network Sequencer

This block is the control heart of a fully connected neural accelerator that runs a fixed encoder–decoder chain. The chain has six weight layers and the widths 784, 128, 64, 32, 64, 128 and 784. A write of the value 1 to the control input starts one inference. The sequencer then walks every layer. A layer begins with a bias cycle and continues with one multiply-accumulate step per input element. A hidden layer ends by committing its results into the shift array with ReLU applied. The final layer ends by streaming its results through the sigmoid and output FIFO path.

The processing-element array is shared and has 128 lanes. The 784-wide output layer is therefore tiled into seven passes: six passes of 128 results and one pass of 16. The results of the last hidden layer are saved to a backup array once. Before every output pass they are copied back into the shift array, so each pass consumes the same operands. In the first layer the operands come from an external pixel stream. An input pixel of zero is consumed without a weight request and without an accumulate step.

The arithmetic, the sigmoid unit, the memories and the bus master sit outside the block. They see only the strobes and handshakes on its ports.

Top module: `layer_sequencer`

## Requirements
- R1: Out of reset the block is idle: busy, done, pixReady, wgtReq, macEn, biasLoad and outValid are all low.
- R2: A control write whose data equals 1 starts a run while the block is idle, and busy is high in the next cycle. A write of any other value, or any write made while busy, has no effect on the run.
- R3: Each layer, and each output pass of the final layer, begins with exactly one biasLoad cycle, so a run has 12. On that cycle activeCnt gives the number of PEs the layer or pass uses: 128, 64, 32, 64, 128, then 128 six times and finally 16.
- R4: In layer 0 the operands come from the pixel stream: srcSel is 0 and every step accepts one pixel, 784 in total. In later layers srcSel is 1 and each step pulses shiftAdvance.
- R5: An accepted pixel equal to zero produces neither macEn nor wgtReq. A nonzero pixel produces one macEn. A run therefore has (nonzero pixels + 1184) accumulate steps.
- R6: macEn and biasLoad occur only in a cycle with wgtValid high. While wgtValid is low the sequencer waits and issues no step.
- R7: Each of the five hidden layers ends with one shiftLoad cycle, and reluEn is high on it.
- R8: backupSave is pulsed once per run, together with the fifth shiftLoad. shiftRestore is pulsed once before each of the 7 output passes.
- R9: Final-layer results are offered with outValid. outIdx counts from 0 to 783 in ascending order. It advances only on a cycle with fifoReady high and holds while fifoReady is low. reluEn is low on these cycles.
- R10: done rises in the cycle after the result with outIdx 783 is accepted, and busy falls at the same time. done stays high until the next accepted start and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | CTRL_W | Control write data; 1 starts a run |
| pixValid | input | 1 | Pixel stream has a value |
| pixData | input | DATA_W | Current pixel value |
| pixReady | output | 1 | Pixel consumed this cycle |
| wgtValid | input | 1 | Weight/bias stream has a row ready |
| wgtReq | output | 1 | Sequencer wants a weight or bias row |
| fifoReady | input | 1 | Output FIFO can take a result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed |
| layerIdx | output | 3 | Current layer, 0 to 5 |
| srcSel | output | 1 | Operand source: 0 pixel stream, 1 shift array |
| biasLoad | output | 1 | Seed active accumulators with bias |
| macEn | output | 1 | One multiply-accumulate step |
| reluEn | output | 1 | ReLU applies to PE outputs (hidden layers) |
| shiftAdvance | output | 1 | Shift array moves to next operand |
| shiftLoad | output | 1 | Commit PE results into the shift array |
| backupSave | output | 1 | Copy shift array into the backup array |
| shiftRestore | output | 1 | Copy backup array back into the shift array |
| activeCnt | output | CNT_W | PEs active in the current layer or pass |
| outValid | output | 1 | A final-layer result is offered to the FIFO |
| outIdx | output | CNT_W | Index of the offered result |

## Verification
Several properties are checked in every cycle by the assertions. Steps and bias loads occur only with weight data present. Zero pixels never cause a step or request. At most one datapath action occurs per cycle. A pixel is consumed only in the first layer. A stalled result holds its index. A valid start makes the block busy. The bench scenarios are needed for the rest: the counts over a whole run (steps, bias loads, commits, restores and results), the per-layer PE counts, the ascending result order, the exact cycle in which done rises, and the fact that ignored control writes leave a run intact. These scenarios vary pixel sparsity and stall density.

// File: rtl/layer_seq_pkg.sv
package layer_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BIAS,
    S_STEP,
    S_COMMIT,
    S_RESTORE,
    S_DRAIN
  } seqState_t;

  // strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clrAll;
    logic incStep;
    logic clrStep;
    logic nextLayer;
    logic incOut;
    logic nextPass;
  } cntCmd_t;

endpackage

// File: rtl/seq_counters.sv
module seq_counters
  import layer_seq_pkg::*;
#(
  parameter int IN_W   = 784,
  parameter int H1_W   = 128,
  parameter int H2_W   = 64,
  parameter int H3_W   = 32,
  parameter int H4_W   = 64,
  parameter int H5_W   = 128,
  parameter int NUM_PE = 128,
  parameter int CNT_W  = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  output logic [2:0]       layerIdx,
  output logic             isFirst,
  output logic             isFinal,
  output logic             isLastHidden,
  output logic             lastStep,
  output logic             lastOut,
  output logic             lastPass,
  output logic [CNT_W-1:0] activeCnt,
  output logic [CNT_W-1:0] outIdx
);

  localparam int LAST_L   = 5;
  localparam int NUM_PASS = (IN_W + NUM_PE - 1) / NUM_PE;
  localparam int LAST_SZ  = IN_W - (NUM_PASS - 1) * NUM_PE;
  localparam int PASS_W   = $clog2(NUM_PASS + 1);

  function automatic int widthOf(input logic [2:0] idx);
    case (idx)
      3'd0:    return IN_W;
      3'd1:    return H1_W;
      3'd2:    return H2_W;
      3'd3:    return H3_W;
      3'd4:    return H4_W;
      3'd5:    return H5_W;
      default: return IN_W;
    endcase
  endfunction

  logic [2:0]        layer;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  outCnt;
  logic [PASS_W-1:0] pass;
  logic [CNT_W-1:0]  inCnt;

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrAll) begin
      layer  <= '0;
      step   <= '0;
      outCnt <= '0;
      pass   <= '0;
    end else begin
      if (cmd.incStep)   step   <= step + 1'b1;
      if (cmd.clrStep)   step   <= '0;
      if (cmd.nextLayer) layer  <= layer + 1'b1;
      if (cmd.incOut)    outCnt <= outCnt + 1'b1;
      if (cmd.nextPass) begin
        pass   <= pass + 1'b1;
        outCnt <= '0;
      end
    end
  end

  always_comb begin
    inCnt    = CNT_W'(widthOf(layer));
    lastPass = (pass == PASS_W'(NUM_PASS - 1));
    if (layer == 3'(LAST_L))
      activeCnt = lastPass ? CNT_W'(LAST_SZ) : CNT_W'(NUM_PE);
    else
      activeCnt = CNT_W'(widthOf(layer + 3'd1));
  end

  assign layerIdx     = layer;
  assign isFirst      = (layer == 3'd0);
  assign isFinal      = (layer == 3'(LAST_L));
  assign isLastHidden = (layer == 3'(LAST_L - 1));
  assign lastStep     = (step == inCnt - 1'b1);
  assign lastOut      = (outCnt == activeCnt - 1'b1);
  assign outIdx       = CNT_W'(pass) * CNT_W'(NUM_PE) + outCnt;

  // R3: tile size never exceeds the PE array
  a_r3_active_fits: assert property (@(posedge clk) disable iff (!rstN)
    activeCnt <= CNT_W'(NUM_PE));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import layer_seq_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  input  logic              wgtValid,
  input  logic              fifoReady,
  input  logic              isFirst,
  input  logic              isFinal,
  input  logic              isLastHidden,
  input  logic              lastStep,
  input  logic              lastOut,
  input  logic              lastPass,
  output cntCmd_t           cmd,
  output logic              busy,
  output logic              done,
  output logic              pixReady,
  output logic              wgtReq,
  output logic              srcSel,
  output logic              biasLoad,
  output logic              macEn,
  output logic              reluEn,
  output logic              shiftAdvance,
  output logic              shiftLoad,
  output logic              backupSave,
  output logic              shiftRestore,
  output logic              outValid
);

  seqState_t state, nextState;
  logic      startHit, doneSet, adv, pixZero;

  assign pixZero  = (pixData == '0);
  assign startHit = ctrlWe && (ctrlWdata == CTRL_W'(1)) && (state == S_IDLE);
  assign busy     = (state != S_IDLE);
  assign reluEn   = busy && !isFinal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      if (startHit)     done <= 1'b0;
      else if (doneSet) done <= 1'b1;
    end
  end

  always_comb begin
    nextState    = state;
    cmd          = '0;
    doneSet      = 1'b0;
    adv          = 1'b0;
    pixReady     = 1'b0;
    wgtReq       = 1'b0;
    srcSel       = !isFirst;
    biasLoad     = 1'b0;
    macEn        = 1'b0;
    shiftAdvance = 1'b0;
    shiftLoad    = 1'b0;
    backupSave   = 1'b0;
    shiftRestore = 1'b0;
    outValid     = 1'b0;
    case (state)
      S_IDLE: if (startHit) begin
        cmd.clrAll = 1'b1;
        nextState  = S_BIAS;
      end
      S_BIAS: begin
        wgtReq = 1'b1;
        if (wgtValid) begin
          biasLoad  = 1'b1;
          nextState = S_STEP;
        end
      end
      S_STEP: begin
        if (isFirst) begin
          if (pixValid && pixZero) begin
            pixReady = 1'b1;
            adv      = 1'b1;
          end else if (pixValid) begin
            wgtReq = 1'b1;
            if (wgtValid) begin
              pixReady = 1'b1;
              macEn    = 1'b1;
              adv      = 1'b1;
            end
          end
        end else begin
          wgtReq = 1'b1;
          if (wgtValid) begin
            macEn        = 1'b1;
            shiftAdvance = 1'b1;
            adv          = 1'b1;
          end
        end
        if (adv && lastStep) begin
          cmd.clrStep = 1'b1;
          nextState   = isFinal ? S_DRAIN : S_COMMIT;
        end else if (adv) begin
          cmd.incStep = 1'b1;
        end
      end
      S_COMMIT: begin
        shiftLoad     = 1'b1;
        backupSave    = isLastHidden;
        cmd.nextLayer = 1'b1;
        nextState     = isLastHidden ? S_RESTORE : S_BIAS;
      end
      S_RESTORE: begin
        shiftRestore = 1'b1;
        nextState    = S_BIAS;
      end
      S_DRAIN: begin
        outValid = 1'b1;
        if (fifoReady && lastOut && lastPass) begin
          doneSet   = 1'b1;
          nextState = S_IDLE;
        end else if (fifoReady && lastOut) begin
          cmd.nextPass = 1'b1;
          nextState    = S_RESTORE;
        end else if (fifoReady) begin
          cmd.incOut = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  a_r6_mac_needs_weight: assert property (@(posedge clk) disable iff (!rstN)
    macEn |-> wgtValid);
  a_r6_bias_needs_weight: assert property (@(posedge clk) disable iff (!rstN)
    biasLoad |-> wgtValid);
  a_r5_zero_skipped: assert property (@(posedge clk) disable iff (!rstN)
    (pixReady && pixData == '0) |-> (!macEn && !wgtReq));
  a_r4_pixel_layer0: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |-> !srcSel);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWdata == CTRL_W'(1) && !busy) |=> (busy && !done));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({biasLoad, macEn, shiftLoad, shiftRestore, outValid}));

endmodule

// File: rtl/layer_sequencer.sv
module layer_sequencer
  import layer_seq_pkg::*;
#(
  parameter int IN_W   = 784,
  parameter int H1_W   = 128,
  parameter int H2_W   = 64,
  parameter int H3_W   = 32,
  parameter int H4_W   = 64,
  parameter int H5_W   = 128,
  parameter int NUM_PE = 128,
  parameter int CTRL_W = 32,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(IN_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  output logic              pixReady,
  input  logic              wgtValid,
  output logic              wgtReq,
  input  logic              fifoReady,
  output logic              busy,
  output logic              done,
  output logic [2:0]        layerIdx,
  output logic              srcSel,
  output logic              biasLoad,
  output logic              macEn,
  output logic              reluEn,
  output logic              shiftAdvance,
  output logic              shiftLoad,
  output logic              backupSave,
  output logic              shiftRestore,
  output logic [CNT_W-1:0]  activeCnt,
  output logic              outValid,
  output logic [CNT_W-1:0]  outIdx
);

  cntCmd_t cmd;
  logic    isFirst, isFinal, isLastHidden, lastStep, lastOut, lastPass;

  seq_ctrl #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .pixValid(pixValid), .pixData(pixData), .wgtValid(wgtValid),
    .fifoReady(fifoReady), .isFirst(isFirst), .isFinal(isFinal),
    .isLastHidden(isLastHidden), .lastStep(lastStep), .lastOut(lastOut),
    .lastPass(lastPass), .cmd(cmd), .busy(busy), .done(done),
    .pixReady(pixReady), .wgtReq(wgtReq), .srcSel(srcSel),
    .biasLoad(biasLoad), .macEn(macEn), .reluEn(reluEn),
    .shiftAdvance(shiftAdvance), .shiftLoad(shiftLoad),
    .backupSave(backupSave), .shiftRestore(shiftRestore),
    .outValid(outValid)
  );

  seq_counters #(
    .IN_W(IN_W), .H1_W(H1_W), .H2_W(H2_W), .H3_W(H3_W), .H4_W(H4_W),
    .H5_W(H5_W), .NUM_PE(NUM_PE), .CNT_W(CNT_W)
  ) uCnt (
    .clk(clk), .rstN(rstN), .cmd(cmd), .layerIdx(layerIdx),
    .isFirst(isFirst), .isFinal(isFinal), .isLastHidden(isLastHidden),
    .lastStep(lastStep), .lastOut(lastOut), .lastPass(lastPass),
    .activeCnt(activeCnt), .outIdx(outIdx)
  );

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !fifoReady) |=> (outValid && $stable(outIdx)));
  a_r9_index_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outIdx < CNT_W'(IN_W) && !reluEn));

endmodule

// File: tb/layer_sequencer_test.sv
`timescale 1ns/1ps
module layer_sequencer_test;

  localparam int IN_W = 784, NUM_PE = 128, CNT_W = 10;
  localparam int HID [5] = '{128, 64, 32, 64, 128};
  localparam int NUM_PASS = 7;

  logic clk = 0, rstN = 0;
  logic ctrlWe = 0;
  logic [31:0] ctrlWdata = 0;
  logic pixValid = 0, wgtValid = 0, fifoReady = 0;
  logic [15:0] pixData = 0;
  logic pixReady, wgtReq, busy, done, srcSel, biasLoad, macEn, reluEn;
  logic shiftAdvance, shiftLoad, backupSave, shiftRestore, outValid;
  logic [2:0] layerIdx;
  logic [CNT_W-1:0] activeCnt, outIdx;

  always #2.5 clk = ~clk;

  layer_sequencer uut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .wgtValid(wgtValid), .wgtReq(wgtReq), .fifoReady(fifoReady),
    .busy(busy), .done(done), .layerIdx(layerIdx), .srcSel(srcSel),
    .biasLoad(biasLoad), .macEn(macEn), .reluEn(reluEn),
    .shiftAdvance(shiftAdvance), .shiftLoad(shiftLoad),
    .backupSave(backupSave), .shiftRestore(shiftRestore),
    .activeCnt(activeCnt), .outValid(outValid), .outIdx(outIdx)
  );

  int checks = 0, fails = 0;
  int pixels [IN_W];
  int pixIdx = 0;
  int wgtPct = 100, pixPct = 100, fifoPct = 100;
  bit accPix = 0, monOn = 0, doneDue = 0;
  int nMac, nBias, nShift, nBackup, nRestore, nOut, nPix, nWgt, expOut;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expActive(input int k);
    if (k < 5) return HID[k];
    return (k < 5 + NUM_PASS - 1) ? NUM_PE : IN_W - (NUM_PASS - 1) * NUM_PE;
  endfunction

  // drive at negedge, sample 1 ns later what the next posedge will capture
  always @(negedge clk) begin
    if (accPix) pixIdx++;
    pixValid  = ($urandom_range(99) < pixPct);
    wgtValid  = ($urandom_range(99) < wgtPct);
    fifoReady = ($urandom_range(99) < fifoPct);
    pixData   = (pixIdx < IN_W) ? 16'(pixels[pixIdx]) : 16'h0;
    #1;
    accPix = pixReady && pixValid;
    if (monOn) begin
      if (doneDue) begin
        chk(done && !busy, "R10", "done after last result", int'(done), 1);
        doneDue = 0;
      end
      if (accPix) begin
        nPix++;
        if (pixData == 0)
          chk(!macEn && !wgtReq, "R5", "zero pixel skipped", int'(macEn | wgtReq), 0);
      end
      if (wgtReq && wgtValid) nWgt++;
      if (macEn) begin
        nMac++;
        chk(wgtValid, "R6", "mac with weight", int'(wgtValid), 1);
        if (nBias == 1) chk(!srcSel && pixReady, "R4", "layer0 from pixels", int'(srcSel), 0);
        else chk(srcSel && shiftAdvance, "R4", "later from shift", int'(srcSel), 1);
      end
      if (biasLoad) begin
        chk(activeCnt == CNT_W'(expActive(nBias)), "R3", "active PEs",
            int'(activeCnt), expActive(nBias));
        nBias++;
      end
      if (shiftLoad) begin
        chk(reluEn, "R7", "relu on commit", int'(reluEn), 1);
        nShift++;
      end
      if (backupSave) begin
        chk(shiftLoad && nShift == 5, "R8", "backup with 5th commit", nShift, 5);
        nBackup++;
      end
      if (shiftRestore) nRestore++;
      if (outValid && fifoReady) begin
        chk(outIdx == CNT_W'(expOut) && !reluEn, "R9", "result index", int'(outIdx), expOut);
        chk(!done, "R10", "done low before end", int'(done), 0);
        if (expOut == IN_W - 1) doneDue = 1;
        expOut++;
        nOut++;
      end
    end
  end

  task automatic ctrlWrite(input logic [31:0] v);
    @(negedge clk);
    ctrlWe = 1; ctrlWdata = v;
    @(negedge clk);
    ctrlWe = 0; ctrlWdata = 0;
  endtask

  task automatic runImage(input int zeroPct, input bit poke);
    int nz = 0;
    int waitCnt = 0;
    for (int i = 0; i < IN_W; i++) begin
      pixels[i] = ($urandom_range(99) < zeroPct) ? 0 : int'($urandom_range(65535, 1));
      if (pixels[i] != 0) nz++;
    end
    pixIdx = 0;
    nMac = 0; nBias = 0; nShift = 0; nBackup = 0; nRestore = 0;
    nOut = 0; nPix = 0; nWgt = 0; expOut = 0; doneDue = 0;
    monOn = 1;
    ctrlWrite(32'd1);
    #1.5;
    chk(busy && !done, "R2", "busy after start", int'(busy), 1);
    chk(!done, "R10", "done cleared by start", int'(done), 0);
    if (poke) begin
      repeat (50) @(negedge clk);
      ctrlWrite(32'd1);   // R2: write while busy is ignored
    end
    while (!done && waitCnt < 60000) begin
      @(negedge clk); #2;
      waitCnt++;
    end
    chk(waitCnt < 60000, "R10", "run completes (watchdog)", waitCnt, 0);
    repeat (2) @(negedge clk);
    monOn = 0;
    chk(nPix == IN_W, "R4", "pixels consumed", nPix, IN_W);
    chk(nMac == nz + 1184, "R5", "accumulate steps", nMac, nz + 1184);
    chk(nBias == 12, "R3", "bias loads", nBias, 12);
    chk(nWgt == nBias + nMac, "R6", "weight rows taken", nWgt, nBias + nMac);
    chk(nShift == 5, "R7", "hidden commits", nShift, 5);
    chk(nBackup == 1, "R8", "backup saves", nBackup, 1);
    chk(nRestore == NUM_PASS, "R8", "restores", nRestore, NUM_PASS);
    chk(nOut == IN_W, "R9", "results", nOut, IN_W);
    chk(done && !busy, "R10", "done holds", int'(done), 1);
  endtask

  initial begin
    void'($urandom(32'hACE1));
    for (int i = 0; i < IN_W; i++) pixels[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1.5;
    // R1: idle out of reset
    chk(!busy && !done && !pixReady && !wgtReq && !macEn && !biasLoad && !outValid,
        "R1", "reset state", int'(busy | done | outValid), 0);
    // R2: non-one value is ignored
    ctrlWrite(32'd2);
    #1.5;
    chk(!busy, "R2", "value 2 ignored", int'(busy), 0);
    ctrlWrite(32'h101);
    #1.5;
    chk(!busy, "R2", "value 0x101 ignored", int'(busy), 0);
    // directed: dense image, no stalls
    runImage(0, 0);
    // directed: all-zero image, write while busy
    runImage(100, 1);
    // random stalls and sparsity
    wgtPct = 60; pixPct = 70; fifoPct = 50;
    runImage(50, 0);
    wgtPct = 30; pixPct = 90; fifoPct = 20;
    runImage(80, 1);
    wgtPct = 85; pixPct = 40; fifoPct = 90;
    runImage(20, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule